// File: doc/BRIEF.md
# Upset-Tolerant Sequencer State Register

A six-state control sequencer whose state register can be held in one of four codings, picked at build time by the `ENC` parameter. The codings trade area against tolerance to a flipped register bit: plain binary (3 bits, no protection), one-hot (6 bits, weak), single-parity "distance-2" (4 bits, detect and recover) and a shortened Hamming "distance-3" code (6 bits, correct a single flip). Every cycle the stored word is checked. A detected illegal word raises an error flag and forces the safe state FAULT. A correctable word is repaired in place and raises a corrected flag for that one cycle.

The sequencer has six states: IDLE, ARM, RUN, WAIT, DONE and FAULT. Its transitions are IDLE to ARM on `start_i`; ARM to RUN, RUN to WAIT and WAIT to DONE on `tick_i`; DONE to IDLE unconditionally; FAULT to IDLE on `tick_i`; and ARM, RUN or WAIT to FAULT on `abort_i`. A fault mask input is XORed into the word written at each clock edge, so upsets can be injected on purpose from outside the block.

Top module: `guarded_seq`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `state_o` reads IDLE and both `err_o` and `corr_o` are low.
- R2: With no upset present, the sequencer makes these moves: IDLE goes to ARM when `start_i` is high, ignoring `tick_i` and `abort_i`. ARM goes to RUN, RUN goes to WAIT and WAIT goes to DONE when `tick_i` is high. DONE goes to IDLE whatever the inputs. FAULT goes to IDLE when `tick_i` is high and ignores `start_i`. In every other case the state holds.
- R3: In ARM, RUN or WAIT, a high `abort_i` moves the machine to FAULT, and it takes priority over `tick_i`.
- R4: `state_o` carries the state index: IDLE=0, ARM=1, RUN=2, WAIT=3, DONE=4, FAULT=5.
- R5: At each rising edge the register captures the encoded next state XOR `flip_i`. An all-zero mask leaves the stored word unchanged.
- R6: Binary coding (`ENC`=ENC_BIN) stores the index in 3 bits. Words 6 and 7 decode as FAULT. A flipped bit that lands on another legal index goes unnoticed. `err_o` and `corr_o` never rise in this coding.
- R7: One-hot coding (ENC_ONEHOT) sets bit i for state i. A word with exactly one set bit is taken as that state. Any other population raises `err_o` and shows FAULT, and the next edge stores a clean FAULT word, so `err_o` drops.
- R8: Distance-2 coding (ENC_DIST2) stores the index in bits [2:0] and an even-parity bit in bit 3. A word with odd parity, or with an index above 5, raises `err_o`, shows FAULT and is replaced by a clean FAULT word at the next edge.
- R9: Distance-3 coding (ENC_DIST3) stores the index in bits [2:0], with bit3=i0^i1, bit4=i0^i2 and bit5=i1^i2. When any single bit is flipped, `state_o` shows the original state, `corr_o` is high for that one cycle, and the next state follows from the repaired state.
- R10: In distance-3 coding, a word whose syndrome is all ones, or whose repaired index is above 5, raises `err_o`, shows FAULT, and is followed by a clean FAULT word.
- R11: `err_o` and `corr_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a sequence from IDLE |
| tick_i | input | 1 | Advances ARM, RUN, WAIT and leaves FAULT |
| abort_i | input | 1 | Sends ARM, RUN or WAIT to FAULT |
| flip_i | input | W (3, 6, 4 or 6 by ENC) | Bit mask XORed into the word written at each edge |
| state_o | output | 3 | Decoded current state index |
| err_o | output | 1 | Illegal state word detected this cycle |
| corr_o | output | 1 | State word repaired this cycle |

## Verification
The clocked properties assume that `flip_i` is zero at the edge that follows a flagged cycle. A fresh upset at that edge could legally change the next word and break the recovery and one-cycle-pulse claims, so each property is qualified on a zero mask at that edge. The bench keeps to this assumption: it raises the mask for exactly one edge and clears it before the next one. It injects only single flips, plus chosen double flips whose outcome is fixed by the coding. Three further copies of the sequencer, one per remaining coding, receive the same condition inputs, so every coding walks the same transition table.

// File: rtl/seq_pkg.sv
package seq_pkg;

    typedef enum logic [1:0] {
        ENC_BIN,
        ENC_ONEHOT,
        ENC_DIST2,
        ENC_DIST3
    } enc_e;

    localparam int unsigned NUM_ST = 6;
    localparam int unsigned IDX_W  = 3;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ST - 1);

    typedef enum logic [IDX_W-1:0] {
        ST_IDLE  = 3'd0,
        ST_ARM   = 3'd1,
        ST_RUN   = 3'd2,
        ST_WAIT  = 3'd3,
        ST_DONE  = 3'd4,
        ST_FAULT = 3'd5
    } st_e;

    // Width of the stored state word for each coding.
    function automatic int unsigned code_width(enc_e e);
        case (e)
            ENC_BIN:    return IDX_W;
            ENC_ONEHOT: return NUM_ST;
            ENC_DIST2:  return IDX_W + 1;
            default:    return IDX_W + 3;
        endcase
    endfunction

endpackage

// File: rtl/seq_next.sv
module seq_next
    import seq_pkg::*;
(
    input  st_e  cur_i,
    input  logic bad_i,
    input  logic start_i,
    input  logic tick_i,
    input  logic abort_i,
    output st_e  nxt_o
);

    always_comb begin
        nxt_o = cur_i;
        if (bad_i) begin
            nxt_o = ST_FAULT;
        end else begin
            unique case (cur_i)
                ST_IDLE:  if (start_i) nxt_o = ST_ARM;
                ST_ARM:   if (abort_i) nxt_o = ST_FAULT;
                          else if (tick_i) nxt_o = ST_RUN;
                ST_RUN:   if (abort_i) nxt_o = ST_FAULT;
                          else if (tick_i) nxt_o = ST_WAIT;
                ST_WAIT:  if (abort_i) nxt_o = ST_FAULT;
                          else if (tick_i) nxt_o = ST_DONE;
                ST_DONE:  nxt_o = ST_IDLE;
                ST_FAULT: if (tick_i) nxt_o = ST_IDLE;
                default:  nxt_o = ST_FAULT;
            endcase
        end
    end

endmodule

// File: rtl/seq_code_enc.sv
module seq_code_enc
    import seq_pkg::*;
#(
    parameter enc_e        ENC = ENC_DIST3,
    parameter int unsigned W   = code_width(ENC)
) (
    input  st_e          st_i,
    output logic [W-1:0] code_o
);

    logic [IDX_W-1:0] idx;
    assign idx = st_i;

    generate
        if (ENC == ENC_BIN) begin : g_bin
            assign code_o = idx;
        end else if (ENC == ENC_ONEHOT) begin : g_onehot
            assign code_o = W'(1) << idx;
        end else if (ENC == ENC_DIST2) begin : g_dist2
            assign code_o = {^idx, idx};
        end else begin : g_dist3
            // check bits cover index bit pairs (0,1), (0,2), (1,2)
            assign code_o = {idx[1] ^ idx[2], idx[0] ^ idx[2], idx[0] ^ idx[1], idx};
        end
    endgenerate

endmodule

// File: rtl/seq_code_chk.sv
module seq_code_chk
    import seq_pkg::*;
#(
    parameter enc_e        ENC = ENC_DIST3,
    parameter int unsigned W   = code_width(ENC)
) (
    input  logic [W-1:0] code_i,
    output st_e          st_o,
    output logic         err_o,
    output logic         corr_o
);

    generate
        if (ENC == ENC_BIN) begin : g_bin
            always_comb begin
                err_o  = 1'b0;
                corr_o = 1'b0;
                st_o   = (code_i > LAST_IDX) ? ST_FAULT : st_e'(code_i);
            end
        end else if (ENC == ENC_ONEHOT) begin : g_onehot
            always_comb begin
                corr_o = 1'b0;
                err_o  = ($countones(code_i) != 1);
                st_o   = ST_FAULT;
                for (int i = 0; i < int'(W); i++) begin
                    if (code_i[i]) st_o = st_e'(IDX_W'(i));
                end
                if (err_o) st_o = ST_FAULT;
            end
        end else if (ENC == ENC_DIST2) begin : g_dist2
            logic [IDX_W-1:0] idx;
            assign idx = code_i[IDX_W-1:0];
            always_comb begin
                corr_o = 1'b0;
                err_o  = (^code_i) | (idx > LAST_IDX);
                st_o   = err_o ? ST_FAULT : st_e'(idx);
            end
        end else begin : g_dist3
            logic [IDX_W-1:0] dat;
            logic [IDX_W-1:0] fix;
            logic [2:0]       syn;
            logic             hard;
            assign dat = code_i[IDX_W-1:0];
            assign syn = {code_i[5] ^ dat[1] ^ dat[2],
                          code_i[4] ^ dat[0] ^ dat[2],
                          code_i[3] ^ dat[0] ^ dat[1]};
            always_comb begin
                fix = dat;
                case (syn)
                    3'b011:  fix = dat ^ 3'b001;
                    3'b101:  fix = dat ^ 3'b010;
                    3'b110:  fix = dat ^ 3'b100;
                    default: fix = dat;
                endcase
                hard   = (syn == 3'b111) || (fix > LAST_IDX);
                err_o  = hard;
                corr_o = (syn != 3'b000) && !hard;
                st_o   = hard ? ST_FAULT : st_e'(fix);
            end
        end
    endgenerate

endmodule

// File: rtl/guarded_seq.sv
module guarded_seq
    import seq_pkg::*;
#(
    parameter  enc_e        ENC = ENC_DIST3,
    localparam int unsigned W   = code_width(ENC)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         tick_i,
    input  logic         abort_i,
    input  logic [W-1:0] flip_i,
    output logic [2:0]   state_o,
    output logic         err_o,
    output logic         corr_o
);

    logic [W-1:0] word_q;
    logic [W-1:0] word_d;
    logic [W-1:0] rst_word;
    st_e          cur;
    st_e          nxt;
    logic         bad;
    logic         fixed;

    seq_code_chk #(.ENC(ENC), .W(W)) u_chk (
        .code_i (word_q),
        .st_o   (cur),
        .err_o  (bad),
        .corr_o (fixed)
    );

    seq_next u_next (
        .cur_i   (cur),
        .bad_i   (bad),
        .start_i (start_i),
        .tick_i  (tick_i),
        .abort_i (abort_i),
        .nxt_o   (nxt)
    );

    seq_code_enc #(.ENC(ENC), .W(W)) u_enc (
        .st_i   (nxt),
        .code_o (word_d)
    );

    seq_code_enc #(.ENC(ENC), .W(W)) u_rst_enc (
        .st_i   (ST_IDLE),
        .code_o (rst_word)
    );

    // State register: the full redundant word is kept, upsets enter here.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= rst_word;
        else        word_q <= word_d ^ flip_i;
    end

    // Output process
    always_comb begin
        state_o = cur;
        err_o   = bad;
        corr_o  = fixed;
    end

endmodule

// File: rtl/seq_guard_chk.sv
module seq_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       tick_i,
    input logic       abort_i,
    input logic       flip_none,
    input logic [2:0] state_o,
    input logic       err_o,
    input logic       corr_o
);

    AST_STATE_RANGE: assert property (@(posedge clk) disable iff (!rst_n) state_o <= 3'd5); // R4
    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(err_o && corr_o)); // R11
    AST_ERR_SAFE: assert property (@(posedge clk) disable iff (!rst_n) (err_o && flip_none) |=> (state_o == 3'd5 && !err_o)); // R7
    AST_CORR_PULSE: assert property (@(posedge clk) disable iff (!rst_n) (corr_o && flip_none) |=> !corr_o); // R9
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (state_o == 3'd4 && flip_none) |=> state_o == 3'd0); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (state_o == 3'd0 && !start_i && flip_none) |=> state_o == 3'd0); // R2
    AST_ABORT_FAULT: assert property (@(posedge clk) disable iff (!rst_n) (state_o >= 3'd1 && state_o <= 3'd3 && abort_i && flip_none) |=> state_o == 3'd5); // R3
    AST_FAULT_EXIT: assert property (@(posedge clk) disable iff (!rst_n) (state_o == 3'd5 && !err_o && tick_i && flip_none) |=> state_o == 3'd0); // R2

    logic unused_ok;
    assign unused_ok = ^{tick_i};

endmodule

bind guarded_seq seq_guard_chk u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .tick_i    (tick_i),
    .abort_i   (abort_i),
    .flip_none (flip_i == '0),
    .state_o   (state_o),
    .err_o     (err_o),
    .corr_o    (corr_o)
);

// File: tb/guarded_seq_tb_top.sv
`timescale 1ns/1ps
module guarded_seq_tb_top;
    import seq_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, tick = 1'b0, abort = 1'b0;
    logic [5:0] flip3 = '0;
    logic [2:0] flipb = '0;
    logic [5:0] flipo = '0;
    logic [3:0] flip2 = '0;

    logic [2:0] st3, stb, sto, st2;
    logic e3, eb, eo, e2, c3, cb, co, c2;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    guarded_seq #(.ENC(ENC_DIST3)) dut_i (.clk(clk), .rst_n(rst_n), .start_i(start), .tick_i(tick),
        .abort_i(abort), .flip_i(flip3), .state_o(st3), .err_o(e3), .corr_o(c3));
    guarded_seq #(.ENC(ENC_BIN)) dut_bin (.clk(clk), .rst_n(rst_n), .start_i(start), .tick_i(tick),
        .abort_i(abort), .flip_i(flipb), .state_o(stb), .err_o(eb), .corr_o(cb));
    guarded_seq #(.ENC(ENC_ONEHOT)) dut_oh (.clk(clk), .rst_n(rst_n), .start_i(start), .tick_i(tick),
        .abort_i(abort), .flip_i(flipo), .state_o(sto), .err_o(eo), .corr_o(co));
    guarded_seq #(.ENC(ENC_DIST2)) dut_d2 (.clk(clk), .rst_n(rst_n), .start_i(start), .tick_i(tick),
        .abort_i(abort), .flip_i(flip2), .state_o(st2), .err_o(e2), .corr_o(c2));

    // {start, tick, abort, expected state}; states IDLE=0 ARM=1 RUN=2 WAIT=3 DONE=4 FAULT=5
    localparam int NV = 21;
    localparam logic [5:0] VEC [NV] = '{
        6'b000_000, 6'b100_001, 6'b100_001, 6'b010_010, 6'b010_011,
        6'b010_100, 6'b100_000, 6'b100_001, 6'b011_101, 6'b100_101,
        6'b010_000, 6'b100_001, 6'b010_010, 6'b001_101, 6'b010_000,
        6'b011_000, 6'b100_001, 6'b010_010, 6'b010_011, 6'b001_101,
        6'b010_000
    };

    task automatic chk(input string req, input string who, input logic [2:0] st_a, input logic e_a,
                       input logic c_a, input logic [2:0] st_x, input logic e_x, input logic c_x);
        n_chk++;
        if ({st_a, e_a, c_a} !== {st_x, e_x, c_x}) begin
            n_bad++;
            $display("FAIL %s %s: state=%0d err=%0b corr=%0b expected state=%0d err=%0b corr=%0b",
                     req, who, st_a, e_a, c_a, st_x, e_x, c_x);
        end
    endtask

    task automatic chk_all(input string req, input logic [2:0] st_x);
        chk(req, "dist3",  st3, e3, c3, st_x, 1'b0, 1'b0);
        chk(req, "binary", stb, eb, cb, st_x, 1'b0, 1'b0);
        chk(req, "onehot", sto, eo, co, st_x, 1'b0, 1'b0);
        chk(req, "dist2",  st2, e2, c2, st_x, 1'b0, 1'b0);
    endtask

    task automatic cyc(input logic s, input logic t, input logic a);
        start = s; tick = t; abort = a;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; start = 0; tick = 0; abort = 0;
        flip3 = '0; flipb = '0; flipo = '0; flip2 = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic to_run();
        do_reset();
        cyc(1, 0, 0);
        cyc(0, 1, 0);
    endtask

    initial begin
        do_reset();
        chk_all("R1 reset", 3'd0);
        @(negedge clk);
        chk_all("R1 after release", 3'd0);

        // R2 R3 R4 R5: transition table, zero mask, all codings together
        for (int i = 0; i < NV; i++) begin
            cyc(VEC[i][5], VEC[i][4], VEC[i][3]);
            chk_all($sformatf("R2 R3 R5 vector %0d", i), VEC[i][2:0]);
        end

        // R9: every single flip of the distance-3 word is repaired
        for (int k = 0; k < 6; k++) begin
            to_run();
            flip3 = 6'(1) << k;
            cyc(0, 0, 0);
            flip3 = '0;
            chk($sformatf("R9 flip bit %0d", k), "dist3", st3, e3, c3, 3'd2, 1'b0, 1'b1);
            cyc(0, 1, 0);
            chk($sformatf("R9 next after bit %0d", k), "dist3", st3, e3, c3, 3'd3, 1'b0, 1'b0);
        end

        // R10: flips of bits 5 and 0 on RUN give syndrome 111
        to_run();
        flip3 = 6'b100001;
        cyc(0, 0, 0);
        flip3 = '0;
        chk("R10 double flip", "dist3", st3, e3, c3, 3'd5, 1'b1, 1'b0);
        cyc(0, 0, 0);
        chk("R10 clean fault", "dist3", st3, e3, c3, 3'd5, 1'b0, 1'b0);
        cyc(0, 1, 0);
        chk("R2 fault exit", "dist3", st3, e3, c3, 3'd0, 1'b0, 1'b0);

        // R7: one-hot population faults
        to_run();
        flipo = 6'b010000;
        cyc(0, 0, 0);
        flipo = '0;
        chk("R7 two bits set", "onehot", sto, eo, co, 3'd5, 1'b1, 1'b0);
        cyc(0, 0, 0);
        chk("R7 clean fault", "onehot", sto, eo, co, 3'd5, 1'b0, 1'b0);
        to_run();
        flipo = 6'b000100;
        cyc(0, 0, 0);
        flipo = '0;
        chk("R7 no bit set", "onehot", sto, eo, co, 3'd5, 1'b1, 1'b0);
        to_run();
        flipo = 6'b010100;
        cyc(0, 0, 0);
        flipo = '0;
        chk("R7 moved single bit", "onehot", sto, eo, co, 3'd4, 1'b0, 1'b0);
        cyc(0, 0, 0);
        chk("R7 moved then DONE->IDLE", "onehot", sto, eo, co, 3'd0, 1'b0, 1'b0);

        // R8: distance-2, RUN word is 4'b1010
        to_run();
        flip2 = 4'b0001;
        cyc(0, 0, 0);
        flip2 = '0;
        chk("R8 index bit flip", "dist2", st2, e2, c2, 3'd5, 1'b1, 1'b0);
        cyc(0, 0, 0);
        chk("R8 clean fault", "dist2", st2, e2, c2, 3'd5, 1'b0, 1'b0);
        to_run();
        flip2 = 4'b1000;
        cyc(0, 0, 0);
        flip2 = '0;
        chk("R8 parity bit flip", "dist2", st2, e2, c2, 3'd5, 1'b1, 1'b0);
        to_run();
        flip2 = 4'b1100;
        cyc(0, 0, 0);
        flip2 = '0;
        chk("R8 index 6 even parity", "dist2", st2, e2, c2, 3'd5, 1'b1, 1'b0);

        // R6: binary has no flags
        to_run();
        flipb = 3'b100;
        cyc(0, 0, 0);
        flipb = '0;
        chk("R6 unused code", "binary", stb, eb, cb, 3'd5, 1'b0, 1'b0);
        cyc(0, 1, 0);
        chk("R6 unused code exit", "binary", stb, eb, cb, 3'd0, 1'b0, 1'b0);
        to_run();
        flipb = 3'b001;
        cyc(0, 0, 0);
        flipb = '0;
        chk("R6 silent jump", "binary", stb, eb, cb, 3'd3, 1'b0, 1'b0);
        cyc(0, 1, 0);
        chk("R6 continues from jump", "binary", stb, eb, cb, 3'd4, 1'b0, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog (R1..all): actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule